// File: doc/BRIEF.md
# Counting Semaphore Cell Bank

This block holds a bank of counting semaphore cells, one for each DMA channel or queue. Each cell has a programmable depth and a counter. Producers and consumers move the counter with push and pop commands. Each command names a cell and an amount. A cell whose count reaches its depth latches a full flag. The flag stays set until software clears it. Full flags whose per-cell enable is set are combined into a single level interrupt.

Software reaches the bank through a simple word-addressed port with a write strobe and a read strobe. The address map has these regions:

- one configuration word per cell;
- one mask word per cell;
- a full status word, cleared by writing 1s;
- an error status word, cleared by writing 1s;
- a read-only word of pending (unmasked and full) cells.

Push and pop arrive on two independent command ports, so both can hit the same cell in one cycle. A push that would overrun the depth, or a pop that would underrun zero, is clamped and recorded in a sticky error flag.

Top module: `sem_cell_bank`

## Requirements
- R1: After reset every cell has depth 1, count 0, mask 0, full 0 and error 0, and `irq` is low.
- R2: A push adds `push_delta` to the count of cell `push_id` at the next clock edge.
- R3: A pop subtracts `pop_delta` from the count of cell `pop_id` at the next clock edge.
- R4: A net result above the depth leaves the count at the depth, and a result below zero leaves it at 0. Either case sets that cell's sticky error bit. The error bit is bit i of the error word at address 2*NCELL+1 and is cleared by writing 1 to it.
- R5: A cell's full bit sets at the clock edge where its new count equals its depth. It stays set while the count later changes. The full bit is bit i of the full word at address 2*NCELL.
- R6: Writing the full word clears each bit written as 1 and leaves bits written as 0 unchanged. A bit cleared while the count still equals the depth reads 0 for one cycle and sets again at the following edge.
- R7: `irq` is registered. It is high exactly when some cell has both its full bit and its mask bit set. The word at address 2*NCELL+2 returns full AND mask. A cell with mask 0 never raises `irq`.
- R8: Writing address i (i < NCELL) loads the depth of cell i from `wr_data[CNT_W-1:0]`. The same write zeroes the count and clears the full and error bits of cell i, and it overrides any command to that cell in that cycle.
- R9: A push and a pop to the same cell in one cycle are applied as one net change. The clamp of R4 is applied to the net result only.
- R10: A read with `rd_en` returns its data on `rd_data` one cycle later, and `rd_data` holds while `rd_en` is low. The read map is as follows:
  - address i returns the depth in bits [CNT_W-1:0] and the count in bits [2*CNT_W-1:CNT_W];
  - address NCELL+i returns the mask in bit 0, and a write to it loads bit 0;
  - unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Registered read data |
| push_vld | input | 1 | Push command valid |
| push_id | input | ID_W | Cell targeted by push |
| push_delta | input | CNT_W | Amount added |
| pop_vld | input | 1 | Pop command valid |
| pop_id | input | ID_W | Cell targeted by pop |
| pop_delta | input | CNT_W | Amount subtracted |
| irq | output | 1 | Level interrupt, OR of masked full bits |

## Verification
The properties assume the following about the inputs:
- command identifiers index a real cell;
- write and command inputs are quiet while reset is held;
- each depth written fits the count width.

With the default 32 cells a 5-bit identifier can only name a real cell. The stimulus drives every input to zero during reset and draws depths and deltas from small ranges. It also confines random cell identifiers to a few cells, so that same-cell push/pop collisions, saturation and re-setting of cleared full bits all occur often.

// File: rtl/sem_pkg.sv
package sem_pkg;

  typedef enum logic [2:0] {
    RK_CFG,
    RK_MASK,
    RK_FULL,
    RK_ERR,
    RK_PEND,
    RK_NONE
  } reg_kind_e;

  // Map a word address onto a register region for a bank of n cells.
  function automatic reg_kind_e classify(input int unsigned a, input int unsigned n);
    if (a < n)            return RK_CFG;
    else if (a < 2 * n)   return RK_MASK;
    else if (a == 2 * n)  return RK_FULL;
    else if (a == 2*n+1)  return RK_ERR;
    else if (a == 2*n+2)  return RK_PEND;
    else                  return RK_NONE;
  endfunction

endpackage

// File: rtl/sem_cmd_decode.sv
module sem_cmd_decode #(
  parameter int NCELL = 32,
  parameter int ID_W  = $clog2(NCELL)
) (
  input  logic            vld,
  input  logic [ID_W-1:0] id,
  output logic [NCELL-1:0] hit
);
  for (genvar i = 0; i < NCELL; i++) begin : g_hit
    assign hit[i] = vld && (id == ID_W'(i));
  end
endmodule

// File: rtl/sem_wr_decode.sv
module sem_wr_decode
  import sem_pkg::*;
#(
  parameter int NCELL  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NCELL-1:0]  cfg_we,
  output logic [NCELL-1:0]  mask_we,
  output logic [NCELL-1:0]  full_clr,
  output logic [NCELL-1:0]  err_clr
);
  reg_kind_e kind;
  assign kind = classify(int'(wr_addr), NCELL);

  for (genvar i = 0; i < NCELL; i++) begin : g_dec
    assign cfg_we[i]   = wr_en && (kind == RK_CFG)  && (int'(wr_addr) == i);
    assign mask_we[i]  = wr_en && (kind == RK_MASK) && (int'(wr_addr) == NCELL + i);
    assign full_clr[i] = wr_en && (kind == RK_FULL) && wr_data[i];
    assign err_clr[i]  = wr_en && (kind == RK_ERR)  && wr_data[i];
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_depth,
  input  logic             mask_we,
  input  logic             mask_in,
  input  logic             full_clr,
  input  logic             err_clr,
  input  logic             push_hit,
  input  logic [CNT_W-1:0] push_delta,
  input  logic             pop_hit,
  input  logic [CNT_W-1:0] pop_delta,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] depth_q,
  output logic             full_q,
  output logic             err_q,
  output logic             mask_q,
  output logic             full_nxt,
  output logic             mask_nxt
);
  localparam int NW = CNT_W + 2;

  logic signed [NW-1:0] inc, dec, net;
  logic                 over, under;
  logic [CNT_W-1:0]     cnt_sat, cnt_nxt, depth_nxt;
  logic                 err_nxt;

  always_comb begin
    inc   = push_hit ? $signed({2'b00, push_delta}) : '0;
    dec   = pop_hit  ? $signed({2'b00, pop_delta})  : '0;
    net   = $signed({2'b00, cnt_q}) + inc - dec;
    over  = net > $signed({2'b00, depth_q});
    under = net < 0;
    if (over)       cnt_sat = depth_q;
    else if (under) cnt_sat = '0;
    else            cnt_sat = net[CNT_W-1:0];
  end

  always_comb begin
    if (cfg_we) begin
      depth_nxt = cfg_depth;
      cnt_nxt   = '0;
      full_nxt  = 1'b0;
      err_nxt   = 1'b0;
    end else begin
      depth_nxt = depth_q;
      cnt_nxt   = cnt_sat;
      full_nxt  = full_clr ? 1'b0 : (full_q | (cnt_sat == depth_q));
      err_nxt   = err_clr  ? 1'b0 : (err_q | over | under);
    end
    mask_nxt = mask_we ? mask_in : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      depth_q <= CNT_W'(1);
      full_q  <= 1'b0;
      err_q   <= 1'b0;
      mask_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      depth_q <= depth_nxt;
      full_q  <= full_nxt;
      err_q   <= err_nxt;
      mask_q  <= mask_nxt;
    end
  end
endmodule

// File: rtl/sem_rd_mux.sv
module sem_rd_mux
  import sem_pkg::*;
#(
  parameter int NCELL  = 32,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [NCELL*CNT_W-1:0] cnt_flat,
  input  logic [NCELL*CNT_W-1:0] dep_flat,
  input  logic [NCELL-1:0]       mask_vec,
  input  logic [NCELL-1:0]       full_vec,
  input  logic [NCELL-1:0]       err_vec,
  output logic [DATA_W-1:0]      rd_data
);
  reg_kind_e        kind;
  int unsigned      a;
  logic [DATA_W-1:0] rd_nxt;

  always_comb begin
    a      = int'(rd_addr);
    kind   = classify(a, NCELL);
    rd_nxt = '0;
    case (kind)
      RK_CFG: begin
        rd_nxt[CNT_W-1:0]       = dep_flat[a*CNT_W +: CNT_W];
        rd_nxt[2*CNT_W-1:CNT_W] = cnt_flat[a*CNT_W +: CNT_W];
      end
      RK_MASK: rd_nxt[0]         = mask_vec[a-NCELL];
      RK_FULL: rd_nxt[NCELL-1:0] = full_vec;
      RK_ERR:  rd_nxt[NCELL-1:0] = err_vec;
      RK_PEND: rd_nxt[NCELL-1:0] = full_vec & mask_vec;
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_nxt;
  end
endmodule

// File: rtl/sem_cell_bank.sv
module sem_cell_bank #(
  parameter int NCELL  = 32,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32,
  parameter int ID_W   = $clog2(NCELL),
  parameter int ADDR_W = $clog2(2*NCELL+3)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              push_vld,
  input  logic [ID_W-1:0]   push_id,
  input  logic [CNT_W-1:0]  push_delta,
  input  logic              pop_vld,
  input  logic [ID_W-1:0]   pop_id,
  input  logic [CNT_W-1:0]  pop_delta,
  output logic              irq
);
  logic [NCELL-1:0]       cfg_we, mask_we, full_clr, err_clr;
  logic [NCELL-1:0]       push_hit, pop_hit;
  logic [NCELL-1:0]       full_vec, err_vec, mask_vec, full_nxt, mask_nxt;
  logic [NCELL*CNT_W-1:0] cnt_flat, dep_flat;

  sem_wr_decode #(.NCELL(NCELL), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wdec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_we(cfg_we), .mask_we(mask_we), .full_clr(full_clr), .err_clr(err_clr)
  );

  sem_cmd_decode #(.NCELL(NCELL), .ID_W(ID_W)) u_push_dec (
    .vld(push_vld), .id(push_id), .hit(push_hit)
  );

  sem_cmd_decode #(.NCELL(NCELL), .ID_W(ID_W)) u_pop_dec (
    .vld(pop_vld), .id(pop_id), .hit(pop_hit)
  );

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    sem_cell #(.CNT_W(CNT_W)) u_cell (
      .clk(clk), .rst(rst),
      .cfg_we(cfg_we[i]), .cfg_depth(wr_data[CNT_W-1:0]),
      .mask_we(mask_we[i]), .mask_in(wr_data[0]),
      .full_clr(full_clr[i]), .err_clr(err_clr[i]),
      .push_hit(push_hit[i]), .push_delta(push_delta),
      .pop_hit(pop_hit[i]), .pop_delta(pop_delta),
      .cnt_q(cnt_flat[i*CNT_W +: CNT_W]), .depth_q(dep_flat[i*CNT_W +: CNT_W]),
      .full_q(full_vec[i]), .err_q(err_vec[i]), .mask_q(mask_vec[i]),
      .full_nxt(full_nxt[i]), .mask_nxt(mask_nxt[i])
    );
  end

  sem_rd_mux #(.NCELL(NCELL), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .cnt_flat(cnt_flat), .dep_flat(dep_flat),
    .mask_vec(mask_vec), .full_vec(full_vec), .err_vec(err_vec),
    .rd_data(rd_data)
  );

  // Interrupt registered from next-state values so it lines up with the flags.
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(full_nxt & mask_nxt);
  end
endmodule

// File: rtl/sem_cell_bank_chk.sv
module sem_cell_bank_chk #(
  parameter int NCELL  = 32,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic [DATA_W-1:0]      wr_data,
  input logic [NCELL*CNT_W-1:0] cnt_flat,
  input logic [NCELL*CNT_W-1:0] dep_flat,
  input logic [NCELL-1:0]       full_vec,
  input logic [NCELL-1:0]       mask_vec,
  input logic                   irq
);
  localparam int FULL_A = 2 * NCELL;

  AST_IRQ_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !irq); // R1

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
    (mask_vec == '0) |-> !irq); // R7

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq |-> |(full_vec & mask_vec)); // R7

  for (genvar i = 0; i < NCELL; i++) begin : g_cell_chk
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      cnt_flat[i*CNT_W +: CNT_W] <= dep_flat[i*CNT_W +: CNT_W]); // R4

    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst)
      ($past(full_vec[i]) &&
       !($past(wr_en) && $past(wr_addr) == ADDR_W'(FULL_A) && $past(wr_data[i])) &&
       !($past(wr_en) && $past(wr_addr) == ADDR_W'(i)))
      |-> full_vec[i]); // R5

    AST_FULL_W1C: assert property (@(posedge clk) disable iff (rst)
      ($past(wr_en) && $past(wr_addr) == ADDR_W'(FULL_A) && $past(wr_data[i]))
      |-> !full_vec[i]); // R6

    AST_CFG_RESTART: assert property (@(posedge clk) disable iff (rst)
      ($past(wr_en) && $past(wr_addr) == ADDR_W'(i))
      |-> (cnt_flat[i*CNT_W +: CNT_W] == '0) && !full_vec[i]); // R8
  end
endmodule

bind sem_cell_bank sem_cell_bank_chk #(
  .NCELL(NCELL), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cnt_flat(cnt_flat), .dep_flat(dep_flat),
  .full_vec(full_vec), .mask_vec(mask_vec), .irq(irq)
);

// File: tb/sim_sem_cell_bank.sv
module sim_sem_cell_bank;
  localparam int NCELL  = 32;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 32;
  localparam int ID_W   = $clog2(NCELL);
  localparam int ADDR_W = $clog2(2*NCELL+3);
  localparam int FULL_A = 2*NCELL;
  localparam int ERR_A  = 2*NCELL+1;
  localparam int PEND_A = 2*NCELL+2;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, rd_en = 0, push_vld = 0, pop_vld = 0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic [ID_W-1:0]   push_id = '0, pop_id = '0;
  logic [CNT_W-1:0]  push_delta = '0, pop_delta = '0;
  logic irq;

  int errors = 0, checks = 0;
  bit done = 0;
  string tag = "R1";

  // Behavioural reference state
  int m_cnt[NCELL], m_dep[NCELL];
  bit m_full[NCELL], m_err[NCELL], m_mask[NCELL];
  longint unsigned m_rd;
  bit m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  sem_cell_bank #(.NCELL(NCELL), .CNT_W(CNT_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .push_vld(push_vld), .push_id(push_id), .push_delta(push_delta),
    .pop_vld(pop_vld), .pop_id(pop_id), .pop_delta(pop_delta), .irq(irq)
  );

  function automatic longint unsigned model_read(int a);
    longint unsigned v = 0;
    if (a < NCELL) v = (longint'(m_cnt[a]) << CNT_W) | longint'(m_dep[a]);
    else if (a < 2*NCELL) v = m_mask[a-NCELL];
    else if (a == FULL_A) begin for (int i = 0; i < NCELL; i++) if (m_full[i]) v |= (64'd1 << i); end
    else if (a == ERR_A)  begin for (int i = 0; i < NCELL; i++) if (m_err[i]) v |= (64'd1 << i); end
    else if (a == PEND_A) begin for (int i = 0; i < NCELL; i++) if (m_full[i] && m_mask[i]) v |= (64'd1 << i); end
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCELL; i++) begin
        m_cnt[i] = 0; m_dep[i] = 1; m_full[i] = 0; m_err[i] = 0; m_mask[i] = 0;
      end
      m_rd = 0; m_irq = 0;
    end else begin
      int a;
      a = int'(wr_addr);
      if (rd_en) m_rd = model_read(int'(rd_addr));
      m_irq = 0;
      for (int i = 0; i < NCELL; i++) begin
        int net, nc;
        bit bad;
        net = m_cnt[i];
        if (push_vld && int'(push_id) == i) net += int'(push_delta);
        if (pop_vld && int'(pop_id) == i)   net -= int'(pop_delta);
        bad = (net > m_dep[i]) || (net < 0);
        nc = (net > m_dep[i]) ? m_dep[i] : (net < 0) ? 0 : net;
        if (wr_en && a == i) begin
          m_dep[i] = int'(wr_data[CNT_W-1:0]);
          m_cnt[i] = 0; m_full[i] = 0; m_err[i] = 0;
        end else begin
          m_full[i] = (wr_en && a == FULL_A && wr_data[i]) ? 0 : (m_full[i] || nc == m_dep[i]);
          m_err[i]  = (wr_en && a == ERR_A && wr_data[i]) ? 0 : (m_err[i] || bad);
          m_cnt[i]  = nc;
        end
        if (wr_en && a == NCELL + i) m_mask[i] = wr_data[0];
        if (m_full[i] && m_mask[i]) m_irq = 1;
      end
    end
  end

  // Per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks += 2;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL %s model irq: actual=%0b expected=%0b", tag, irq, m_irq);
      end
      if (rd_data !== DATA_W'(m_rd)) begin
        errors++;
        $display("FAIL %s model rd_data: actual=%0h expected=%0h", tag, rd_data, m_rd);
      end
    end
  end

  task automatic check(string t, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  task automatic wr(int a, longint unsigned d);
    wr_en = 1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic cmd(bit pu, int pid, int pd, bit po, int qid, int qd);
    push_vld = pu; push_id = ID_W'(pid); push_delta = CNT_W'(pd);
    pop_vld = po;  pop_id = ID_W'(qid);  pop_delta = CNT_W'(qd);
    @(negedge clk);
    push_vld = 0; pop_vld = 0;
  endtask

  task automatic expect_rd(int a, longint unsigned exp, string t);
    rd_en = 1; rd_addr = ADDR_W'(a);
    @(negedge clk);
    rd_en = 0;
    check(t, rd_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    tag = "R1";
    check("R1 irq after reset", irq, 0);
    expect_rd(0, 64'h1, "R1 cell0 depth1 count0");
    expect_rd(FULL_A, 0, "R1 full word");
    expect_rd(NCELL+9, 0, "R1 mask");
    // R5/R7 full and interrupt
    tag = "R5";
    wr(NCELL+3, 1);
    cmd(1, 3, 1, 0, 0, 0);
    check("R5 R7 irq on full", irq, 1);
    expect_rd(FULL_A, 64'h8, "R5 full bit3");
    expect_rd(PEND_A, 64'h8, "R7 pending word");
    // R7 unmasked cell, R6 re-set after clear
    tag = "R6";
    cmd(1, 5, 1, 0, 0, 0);
    wr(FULL_A, 64'h8);
    check("R6 R7 irq dropped after clear", irq, 0);
    @(negedge clk);
    check("R6 full re-set", irq, 1);
    expect_rd(FULL_A, 64'h28, "R6 full word");
    // R2/R3/R9/R4 counting
    tag = "R2";
    wr(7, 10);
    cmd(1, 7, 3, 0, 0, 0);
    cmd(1, 7, 4, 0, 0, 0);
    expect_rd(7, (7 << 8) | 10, "R2 push adds");
    tag = "R3";
    cmd(0, 0, 0, 1, 7, 2);
    expect_rd(7, (5 << 8) | 10, "R3 pop subtracts");
    tag = "R9";
    cmd(1, 7, 5, 1, 7, 1);
    expect_rd(7, (9 << 8) | 10, "R9 net update");
    cmd(1, 7, 3, 1, 7, 2);
    expect_rd(7, (10 << 8) | 10, "R9 net reaches depth no clamp");
    expect_rd(ERR_A, 0, "R9 no error when net fits");
    tag = "R4";
    cmd(1, 7, 9, 0, 0, 0);
    expect_rd(7, (10 << 8) | 10, "R4 saturate at depth");
    expect_rd(ERR_A, 64'h80, "R4 error set");
    wr(ERR_A, 64'h80);
    expect_rd(ERR_A, 0, "R4 error cleared");
    cmd(0, 0, 0, 1, 7, 20);
    expect_rd(7, 10, "R4 saturate at zero");
    expect_rd(ERR_A, 64'h80, "R4 error on underflow");
    // R8 configuration write
    tag = "R8";
    wr(7, 4);
    expect_rd(7, 4, "R8 depth loaded count zero");
    expect_rd(ERR_A, 0, "R8 error cleared");
    expect_rd(FULL_A, 64'h28, "R8 full bit7 cleared");
    // R10 read port behaviour
    tag = "R10";
    expect_rd(NCELL+3, 1, "R10 mask readback");
    repeat (3) @(negedge clk);
    check("R10 rd_data holds", rd_data, 1);
    expect_rd(100, 0, "R10 unmapped address");
    // Random traffic compared against the model every cycle
    tag = "R9 random";
    for (int n = 0; n < 4000; n++) begin
      push_vld = ($urandom_range(0, 2) != 0); push_id = ID_W'($urandom_range(0, 5));
      push_delta = CNT_W'($urandom_range(0, 5));
      pop_vld = ($urandom_range(0, 2) != 0); pop_id = ID_W'($urandom_range(0, 5));
      pop_delta = CNT_W'($urandom_range(0, 5));
      rd_en = $urandom_range(0, 1); rd_addr = ADDR_W'($urandom_range(0, 2*NCELL+4));
      wr_en = ($urandom_range(0, 7) == 0);
      case ($urandom_range(0, 3))
        0: begin wr_addr = ADDR_W'($urandom_range(0, 5)); wr_data = DATA_W'($urandom_range(0, 12)); end
        1: begin wr_addr = ADDR_W'(NCELL + $urandom_range(0, 5)); wr_data = DATA_W'($urandom_range(0, 1)); end
        2: begin wr_addr = ADDR_W'(FULL_A); wr_data = $urandom; end
        default: begin wr_addr = ADDR_W'(ERR_A); wr_data = $urandom; end
      endcase
      @(negedge clk);
    end
    push_vld = 0; pop_vld = 0; wr_en = 0; rd_en = 0;
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule